// File: doc/BRIEF.md
# MFM Write Stream Command Decoder

This block sits between a write FIFO and an MFM bit encoder. It takes 16-bit words from the FIFO through a ready/valid handshake and turns them into a byte stream for the encoder. Each output byte is tagged as ordinary data or as a mark byte that must be written with a missing clock. A word whose upper byte is the escape value 0x99 carries a command in its lower byte. Commands emit sync marks and address or data identifiers, insert the running CRC, open a transparent window for the sector payload, or end the write. Any other word produces its two bytes as data, upper byte first.

A whole sector write is one stream of words: gap filler, zero sync, three A1 marks, the data identifier, a payload window, the CRC command, more gap and the stop command. The block keeps a CRC-16 over the field. The CRC is preset by the first A1 mark of a run. The decoder emits at most one byte per cycle. It lowers `in_ready` for one cycle whenever a second byte is still owed, either the lower byte of a data word or the low CRC byte.

Top module: `mfm_esc_decoder`

## Requirements
- R1: A word with upper byte not 0x99 emits its upper byte, then its lower byte, as data (`out_mark`=0) on two consecutive cycles. `in_ready` is low during the cycle the lower byte is emitted.
- R2: The escape is recognised only in the upper byte. A word such as 0x4E99 emits 0x4E then 0x99 as data.
- R3: Word 0x99A1 emits 0xA1 with `out_mark`=1. Word 0x99C2 emits 0xC2 with `out_mark`=1.
- R4: Words 0x99FE and 0x99FB emit 0xFE or 0xFB as a data byte.
- R5: Word 0x990F causes the next BYPASS_BYTES bytes (BYPASS_BYTES/2 words) to pass through as data with no escape decoding. Escape decoding resumes after that.
- R6: Word 0x9904 emits the CRC as two data bytes, high byte first. `in_ready` is low while the low byte is emitted.
- R7: The CRC is polynomial 0x1021, MSB first. It is preset to 0xFFFF when an A1 mark is emitted and the byte emitted just before it was not an A1 mark. It covers A1 marks, identifiers and data bytes. It excludes C2 marks and CRC bytes.
- R8: Word 0x9908 emits no byte and drops `wr_gate`. `wr_gate` rises with the first byte emitted.
- R9: Word 0x9999 emits one literal 0x99 data byte.
- R10: An escape word with any other command byte emits nothing and pulses `cmd_err` high for one cycle.
- R11: After reset, `out_valid`, `wr_gate` and `cmd_err` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Decoder can accept a word |
| in_word | input | 16 | Stream word, upper byte first |
| out_valid | output | 1 | Output byte valid this cycle |
| out_byte | output | 8 | Output byte |
| out_mark | output | 1 | Byte is a missing-clock mark |
| wr_gate | output | 1 | Write in progress |
| cmd_err | output | 1 | Unknown command pulse |

## Verification
The bench builds the decoder with BYPASS_BYTES set to 8. A complete sector frame therefore fits in a short vector table. Escape-looking words such as 0x9904 and 0x9908 sit inside that window, which shows they pass through raw. The CRC and stop commands after the window then show that decoding resumes exactly at the window's end. The CRC preset, the exclusion of C2 marks from the CRC, and the upper-byte-only escape are covered by directed words after the frame.

// File: rtl/mfm_esc_decoder.sv
module mfm_esc_decoder #(
  parameter int BYPASS_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_word,
  output logic        out_valid,
  output logic [7:0]  out_byte,
  output logic        out_mark,
  output logic        wr_gate,
  output logic        cmd_err
);
  localparam int BW = BYPASS_BYTES / 2;
  localparam int CW = $clog2(BW + 1);
  localparam logic [7:0] ESC = 8'h99, SYNC_A1 = 8'hA1, SYNC_C2 = 8'hC2;
  localparam logic [7:0] ID_AM = 8'hFE, ID_DM = 8'hFB;
  localparam logic [7:0] CMD_BYP = 8'h0F, CMD_CRC = 8'h04, CMD_STOP = 8'h08;

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ b[i]) ? 16'h1021 : 16'h0000);
    return r;
  endfunction

  logic [CW-1:0] byp;
  logic          pend, pend_crc, a1_run;
  logic [7:0]    pend_byte;
  logic [15:0]   crc;

  assign in_ready = !pend;
  wire       take = in_valid && in_ready;
  wire [7:0] hi   = in_word[15:8];
  wire [7:0] lo   = in_word[7:0];
  wire       esc  = (byp == '0) && (hi == ESC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp <= '0; pend <= 1'b0; pend_crc <= 1'b0; pend_byte <= '0;
      a1_run <= 1'b0; crc <= 16'hFFFF;
      out_valid <= 1'b0; out_byte <= '0; out_mark <= 1'b0;
      wr_gate <= 1'b0; cmd_err <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_mark  <= 1'b0;
      cmd_err   <= 1'b0;
      if (pend) begin
        pend      <= 1'b0;
        out_valid <= 1'b1;
        out_byte  <= pend_byte;
        if (!pend_crc) begin
          crc    <= crc_upd(crc, pend_byte);
          a1_run <= 1'b0;
        end
      end else if (take) begin
        if (!esc) begin
          out_valid <= 1'b1;
          out_byte  <= hi;
          wr_gate   <= 1'b1;
          crc       <= crc_upd(crc, hi);
          a1_run    <= 1'b0;
          pend      <= 1'b1;
          pend_byte <= lo;
          pend_crc  <= 1'b0;
          if (byp != '0) byp <= byp - 1'b1;
        end else begin
          case (lo)
            SYNC_A1: begin
              out_valid <= 1'b1; out_byte <= lo; out_mark <= 1'b1; wr_gate <= 1'b1;
              crc    <= crc_upd(a1_run ? crc : 16'hFFFF, lo);
              a1_run <= 1'b1;
            end
            SYNC_C2: begin
              out_valid <= 1'b1; out_byte <= lo; out_mark <= 1'b1; wr_gate <= 1'b1;
              a1_run <= 1'b0;
            end
            ID_AM, ID_DM, ESC: begin
              out_valid <= 1'b1; out_byte <= lo; wr_gate <= 1'b1;
              crc    <= crc_upd(crc, lo);
              a1_run <= 1'b0;
            end
            CMD_BYP: byp <= CW'(BW);
            CMD_CRC: begin
              out_valid <= 1'b1; out_byte <= crc[15:8]; wr_gate <= 1'b1;
              pend      <= 1'b1;
              pend_byte <= crc[7:0];
              pend_crc  <= 1'b1;
              a1_run    <= 1'b0;
            end
            CMD_STOP: wr_gate <= 1'b0;
            default:  cmd_err <= 1'b1;
          endcase
        end
      end
    end
  end
endmodule

module mfm_esc_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_word,
  input logic        out_valid,
  input logic [7:0]  out_byte,
  input logic        out_mark,
  input logic        wr_gate,
  input logic        cmd_err
);
  // R1
  plain_hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_word[15:8] != 8'h99) |=>
      (out_valid && !out_mark && out_byte == $past(in_word[15:8]) && !in_ready));
  // R1
  plain_lo_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_word[15:8] != 8'h99) |=> ##1
      (out_valid && !out_mark && out_byte == $past(in_word[7:0], 2)));
  // R3
  mark_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_mark |-> (out_valid && (out_byte == 8'hA1 || out_byte == 8'hC2)));
  // R6
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  // R8
  stop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_gate) |-> !out_valid);
  // R10
  err_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !out_valid);
endmodule

bind mfm_esc_decoder mfm_esc_decoder_chk u_chk (.*);

// File: tb/mfm_esc_decoder_tb.sv
`timescale 1ns/1ps
module mfm_esc_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic in_ready, out_valid, out_mark, wr_gate, cmd_err;
  logic [7:0] out_byte;
  int nchk = 0, nerr = 0, ncap = 0, nerrp = 0;
  logic [8:0] cap [0:127];
  bit done = 1'b0;

  always #5 clk = ~clk;

  mfm_esc_decoder #(.BYPASS_BYTES(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_byte(out_byte),
    .out_mark(out_mark), .wr_gate(wr_gate), .cmd_err(cmd_err));

  localparam int NS = 16;
  localparam logic [15:0] STIM [NS] = '{
    16'h4E4E, 16'h4E4E, 16'h0000, 16'h0000, 16'h99A1, 16'h99A1, 16'h99A1, 16'h99FB,
    16'h990F, 16'h9904, 16'h9908, 16'h1234, 16'h990F, 16'h9904, 16'h4E4E, 16'h9908};
  localparam int NE = 24;
  localparam logic [8:0] EXP [NE] = '{
    9'h04E, 9'h04E, 9'h04E, 9'h04E, 9'h000, 9'h000, 9'h000, 9'h000,
    9'h1A1, 9'h1A1, 9'h1A1, 9'h0FB, 9'h099, 9'h004, 9'h099, 9'h008,
    9'h012, 9'h034, 9'h099, 9'h00F, 9'h000, 9'h000, 9'h04E, 9'h04E};

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (out_valid && ncap < 128) begin cap[ncap] = {out_mark, out_byte}; ncap++; end
    if (cmd_err) nerrp++;
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    in_word = w; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(100000 * 10);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] c;
    int base;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!out_valid && !wr_gate && !cmd_err && in_ready, "R11", {12'd0, out_valid, wr_gate, cmd_err, in_ready}, 16'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NS; i++) begin
      send(STIM[i]);
      if (i == 0) chk(wr_gate, "R8 gate rises", {15'd0, wr_gate}, 16'd1);
    end
    drain();
    chk(!wr_gate, "R8 stop", {15'd0, wr_gate}, 16'd0);
    chk(ncap == NE, "R1 frame byte count", ncap[15:0], NE[15:0]);
    c = 16'hFFFF;
    for (int i = 8; i < 20; i++) c = ref_crc(c, EXP[i][7:0]);
    for (int i = 0; i < NE; i++) begin
      logic [8:0] e;
      e = EXP[i];
      if (i == 20) e = {1'b0, c[15:8]};
      if (i == 21) e = {1'b0, c[7:0]};
      chk(cap[i] == e, (i >= 20) ? "R6 R7 crc" : (i >= 12) ? "R5 bypass" : (i >= 8) ? "R3 R4 marks" : "R1 data",
          {7'd0, cap[i]}, {7'd0, e});
    end

    base = ncap;
    send(16'h4E99);
    chk(!in_ready, "R1 stall", {15'd0, in_ready}, 16'd0);
    drain();
    chk(ncap == base + 2 && cap[base] == 9'h04E && cap[base+1] == 9'h099, "R2",
        {7'd0, cap[base+1]}, 16'h0099);

    base = ncap;
    send(16'h9999); drain();
    chk(ncap == base + 1 && cap[base] == 9'h099, "R9", {7'd0, cap[base]}, 16'h0099);

    base = ncap;
    send(16'h9955); drain();
    chk(ncap == base && nerrp == 1, "R10", nerrp[15:0], 16'd1);

    base = ncap;
    send(16'h99FE); drain();
    chk(ncap == base + 1 && cap[base] == 9'h0FE, "R4", {7'd0, cap[base]}, 16'h00FE);

    base = ncap;
    send(16'h99A1); send(16'h99C2); send(16'h9904);
    chk(!in_ready, "R6 stall", {15'd0, in_ready}, 16'd0);
    drain();
    c = ref_crc(16'hFFFF, 8'hA1);
    chk(cap[base] == 9'h1A1 && cap[base+1] == 9'h1C2, "R3 marks", {7'd0, cap[base+1]}, 16'h01C2);
    chk(ncap == base + 4 && cap[base+2] == {1'b0, c[15:8]} && cap[base+3] == {1'b0, c[7:0]}, "R7 preset",
        {cap[base+2][7:0], cap[base+3][7:0]}, c);

    send(16'h9908); drain();
    chk(!wr_gate, "R8 second stop", {15'd0, wr_gate}, 16'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule